// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power synchronous DRAM and brings the memory from power-on to a usable state. After reset it holds the command pins idle, with clock enable and the data mask high, for a start-up pause. The pause is counted in clock cycles from a clock-frequency parameter and a pause length in microseconds. It then closes every bank with a precharge-all command and issues a fixed number of auto-refresh commands. Next it loads the normal mode register and then the low-power mode register. Between commands it inserts parameterized NOP gaps.

The sequence order is fixed: pause, precharge-all, the auto-refresh commands, normal mode-register load, low-power mode-register load. Both register loads use the same pin encoding. The bank-address pins tell them apart: zero for the normal register and `2'b10` for the low-power register. The value to load into each register comes in on input ports. When the last gap has elapsed, a ready flag rises and stays high until the next reset. The data mask drops low in the same cycle. Read/write traffic, periodic refresh and self-refresh entry belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), cke = 1, dqm = 1 and init_done = 0.
- R2: After reset is released the pins show only NOP, with cke and dqm high, for at least CLK_MHZ*PAUSE_US cycles before the first command.
- R3: The first command is precharge-all: code 4'b0010 with address bit AP_BIT (default 10) high.
- R4: Commands occur in exactly this order: one precharge, REF_COUNT auto-refreshes (code 4'b0001), one mode-register load with ba = 0, one mode-register load with ba = 2'b10 (load code 4'b0000). No other command follows.
- R5: The next command comes exactly T_RP cycles after the precharge, exactly T_RFC cycles after each auto-refresh, and exactly T_MRD cycles after the normal mode-register load. Every cycle between two commands is a NOP.
- R6: The normal mode-register load drives ba = 0 and addr = mode_cfg.
- R7: The low-power load drives ba = 2'b10 and an address with lp_tcr in bits [4:3], lp_pasr in bits [2:0] and all other bits zero. PASR codes: 000 all banks, 001 banks 0 and 1, 010 bank 0, 101 half of bank 0, 110 quarter of bank 0. TCR takes four codes, 00 to 11.
- R8: cke stays high on every cycle after reset, so it is high on the cycle before each mode-register load.
- R9: init_done rises exactly T_MRD cycles after the low-power load, and dqm falls in the same cycle. init_done then stays high and the pins stay NOP until reset.
- R10: A reset during the sequence returns the pins to the R1 state. The full sequence, including the pause, then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | ADDR_W | Value loaded into the normal mode register |
| lp_pasr | input | 3 | Partial-array self-refresh code for the low-power register |
| lp_tcr | input | 2 | Temperature-compensated refresh code for the low-power register |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address pins |
| init_done | output | 1 | Ready flag, sticky until reset |

## Verification
The embedded assertions check these rules on every cycle: idle pins during the pause, the precharge-all bit, bank address and address contents for each register load, clock enable high before each mode-set, a NOP right after every mode-set, and the ready flag staying high. Only the bench scenarios can show the exact command order and the total refresh count. They also show that the gaps between commands equal the parameters exactly, that the pause is long enough in cycles, and that a reset in the middle of the sequence restarts it from the pause. A cycle-accurate command monitor records every non-NOP command with its cycle number for those checks.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_MRS,
    ST_TMRD_A,
    ST_LMR,
    ST_TMRD_B,
    ST_DONE
  } init_state_e;

  localparam logic [1:0] BA_NORMAL = 2'b00;
  localparam logic [1:0] BA_LOWPWR = 2'b10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // a load always takes effect on the next cycle
  a_r5_load_taken: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mask,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_cke  <= 1'b1;
      sd_dqm  <= 1'b1;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd;
      sd_cke  <= 1'b1;
      sd_dqm  <= mask;
      sd_ba   <= ba;
      sd_addr <= addr;
    end
  end

  logic pin_mset;
  assign pin_mset = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_MRS);

  a_r8_cke_before_mset: assert property (@(posedge clk) disable iff (rst)
    pin_mset |-> ($past(sd_cke) && sd_cke));

  a_r5_nop_after_mset: assert property (@(posedge clk) disable iff (rst)
    pin_mset |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int PAUSE_US  = 200,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int REF_COUNT = 2,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_cfg,
  input  logic [2:0]        lp_pasr,
  input  logic [1:0]        lp_tcr,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_dqm,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int T_MAX     = max2(max2(PAUSE_CYC, T_RP), max2(T_RFC, T_MRD));
  localparam int TW        = $clog2(T_MAX + 1);
  localparam int RCW       = $clog2(REF_COUNT + 1);

  init_state_e       state_q, state_d;
  logic [RCW-1:0]    ref_q, ref_d;
  logic              done_q;

  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_exp;

  sd_cmd_e           cmd_c;
  logic [1:0]        ba_c;
  logic [ADDR_W-1:0] addr_c;
  logic [ADDR_W-1:0] lp_word;

  always_comb begin
    lp_word      = '0;
    lp_word[2:0] = lp_pasr;
    lp_word[4:3] = lp_tcr;
  end

  init_wait_timer #(
    .W       (TW),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    state_d  = state_q;
    ref_d    = ref_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd_c    = CMD_NOP;
    ba_c     = '0;
    addr_c   = '0;
    unique case (state_q)
      ST_PAUSE: if (tmr_exp) state_d = ST_PRE;
      ST_PRE: begin
        cmd_c          = CMD_PRE;
        addr_c[AP_BIT] = 1'b1;
        tmr_load       = 1'b1;
        tmr_val        = TW'(T_RP - 2);
        state_d        = ST_TRP;
      end
      ST_TRP: if (tmr_exp) state_d = ST_REF;
      ST_REF: begin
        cmd_c    = CMD_REF;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_RFC - 2);
        ref_d    = ref_q + 1'b1;
        state_d  = ST_TRFC;
      end
      ST_TRFC: if (tmr_exp) state_d = (ref_q == RCW'(REF_COUNT)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        cmd_c    = CMD_MRS;
        ba_c     = BA_NORMAL;
        addr_c   = mode_cfg;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_MRD - 2);
        state_d  = ST_TMRD_A;
      end
      ST_TMRD_A: if (tmr_exp) state_d = ST_LMR;
      ST_LMR: begin
        cmd_c    = CMD_MRS;
        ba_c     = BA_LOWPWR;
        addr_c   = lp_word;
        tmr_load = 1'b1;
        tmr_val  = TW'(T_MRD - 2);
        state_d  = ST_TMRD_B;
      end
      ST_TMRD_B: if (tmr_exp) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_PAUSE;
      ref_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      done_q  <= (state_q == ST_DONE);
    end
  end

  assign init_done = done_q;

  init_cmd_drive #(
    .ADDR_W (ADDR_W)
  ) u_drive (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd_c),
    .ba       (ba_c),
    .addr     (addr_c),
    .mask     (state_q != ST_DONE),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_cke   (sd_cke),
    .sd_dqm   (sd_dqm),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr)
  );

  logic [3:0] pin_cmd;
  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r2_pause_idle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PAUSE) |=> (pin_cmd == CMD_NOP && sd_cke && sd_dqm));

  a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE) |=> (pin_cmd == CMD_PRE && sd_addr[AP_BIT]));

  a_r6_normal_load: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MRS) |=> (sd_ba == BA_NORMAL && sd_addr == $past(mode_cfg)));

  a_r7_lowpower_load: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LMR) |=> (sd_ba == BA_LOWPWR &&
                             sd_addr[2:0] == $past(lp_pasr) &&
                             sd_addr[4:3] == $past(lp_tcr)));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && pin_cmd == CMD_NOP && !sd_dqm));

endmodule

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;

  localparam int CLK_MHZ   = 125;
  localparam int PAUSE_US  = 4;
  localparam int T_RP      = 3;
  localparam int T_RFC     = 8;
  localparam int T_MRD     = 2;
  localparam int REF_COUNT = 2;
  localparam int ADDR_W    = 13;
  localparam int AP_BIT    = 10;
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int NCMD      = REF_COUNT + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] mode_cfg = '0;
  logic [2:0] lp_pasr = '0;
  logic [1:0] lp_tcr = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm, init_done;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  always #4 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u0 (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .lp_pasr(lp_pasr), .lp_tcr(lp_tcr),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_cke(cke), .sd_dqm(dqm), .sd_ba(ba), .sd_addr(addr), .init_done(init_done)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-accurate command monitor
  int cyc;
  int m_n;
  logic [3:0]        m_cmd  [16];
  int                m_cyc  [16];
  logic [1:0]        m_ba   [16];
  logic [ADDR_W-1:0] m_addr [16];
  int done_cyc;
  int done_drop;
  int cke_low;
  int dqm_bad;
  int pause_bad;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; m_n = 0; done_cyc = -1; done_drop = 0;
      cke_low = 0; dqm_bad = 0; pause_bad = 0;
    end else begin
      cyc++;
      if (!cke) cke_low++;
      if (done_cyc >= 0 && !init_done) done_drop++;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      if (dqm == init_done) dqm_bad++;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (m_n == 0 && (!cke || !dqm)) pause_bad++;
        if (m_n < 16) begin
          m_cmd[m_n] = {cs_n, ras_n, cas_n, we_n};
          m_cyc[m_n] = cyc;
          m_ba[m_n] = ba;
          m_addr[m_n] = addr;
        end
        m_n++;
      end else if (m_n == 0 && (!cke || !dqm)) begin
        pause_bad++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < PAUSE_CYC + 500 && !init_done; i++) @(negedge clk);
  endtask

  task automatic check_sequence(input string tag);
    logic [ADDR_W-1:0] lpw;
    chk(m_n == NCMD, {tag, " R4 command count"}, m_n, NCMD);
    chk(m_cyc[0] >= PAUSE_CYC, {tag, " R2 pause length"}, m_cyc[0], PAUSE_CYC);
    chk(pause_bad == 0, {tag, " R2 cke/dqm high in pause"}, pause_bad, 0);
    chk(m_cmd[0] == 4'b0010 && m_addr[0][AP_BIT], {tag, " R3 precharge-all first"},
        {m_cmd[0], m_addr[0]}, {4'b0010, 13'h0400});
    for (int k = 1; k <= REF_COUNT; k++) begin
      chk(m_cmd[k] == 4'b0001, {tag, " R4 refresh"}, m_cmd[k], 4'b0001);
      chk(m_cyc[k] - m_cyc[k-1] == ((k == 1) ? T_RP : T_RFC), {tag, " R5 gap before refresh"},
          m_cyc[k] - m_cyc[k-1], (k == 1) ? T_RP : T_RFC);
    end
    chk(m_cmd[REF_COUNT+1] == 4'b0000 && m_ba[REF_COUNT+1] == 2'b00,
        {tag, " R4 normal load"}, {m_cmd[REF_COUNT+1], m_ba[REF_COUNT+1]}, 6'b0);
    chk(m_cyc[REF_COUNT+1] - m_cyc[REF_COUNT] == T_RFC, {tag, " R5 gap after last refresh"},
        m_cyc[REF_COUNT+1] - m_cyc[REF_COUNT], T_RFC);
    chk(m_addr[REF_COUNT+1] == mode_cfg, {tag, " R6 normal load address"},
        m_addr[REF_COUNT+1], mode_cfg);
    lpw = '0; lpw[2:0] = lp_pasr; lpw[4:3] = lp_tcr;
    chk(m_cmd[REF_COUNT+2] == 4'b0000 && m_ba[REF_COUNT+2] == 2'b10,
        {tag, " R4/R7 low-power load"}, {m_cmd[REF_COUNT+2], m_ba[REF_COUNT+2]}, {4'b0000, 2'b10});
    chk(m_addr[REF_COUNT+2] == lpw, {tag, " R7 low-power word"}, m_addr[REF_COUNT+2], lpw);
    chk(m_cyc[REF_COUNT+2] - m_cyc[REF_COUNT+1] == T_MRD, {tag, " R5 gap after normal load"},
        m_cyc[REF_COUNT+2] - m_cyc[REF_COUNT+1], T_MRD);
    chk(done_cyc - m_cyc[REF_COUNT+2] == T_MRD, {tag, " R9 ready timing"},
        done_cyc - m_cyc[REF_COUNT+2], T_MRD);
    chk(cke_low == 0, {tag, " R8 cke high"}, cke_low, 0);
    chk(dqm_bad == 0, {tag, " R9 dqm falls with ready"}, dqm_bad, 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke && dqm && !init_done,
        "R1 pins in reset", {cs_n, ras_n, cas_n, we_n, cke, dqm, init_done}, 7'b0111110);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke && dqm && !init_done,
        "R1 pins after release", {cs_n, ras_n, cas_n, we_n, cke, dqm, init_done}, 7'b0111110);
  endtask

  task automatic t_full(input logic [ADDR_W-1:0] mc, input logic [2:0] p,
                        input logic [1:0] t, input string tag);
    mode_cfg = mc; lp_pasr = p; lp_tcr = t;
    do_reset();
    wait_done();
    chk(init_done, {tag, " R9 ready reached"}, init_done, 1);
    repeat (30) @(negedge clk);
    check_sequence(tag);
    chk(init_done && done_drop == 0, {tag, " R9 ready sticky"}, done_drop, 0);
  endtask

  task automatic t_mid_reset();
    mode_cfg = 13'h0033; lp_pasr = 3'b110; lp_tcr = 2'b01;
    do_reset();
    for (int i = 0; i < PAUSE_CYC + 100 && m_n < 2; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke && dqm && !init_done,
        "R10 pins after mid-sequence reset", {cs_n, ras_n, cas_n, we_n, cke, dqm, init_done},
        7'b0111110);
    rst = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    check_sequence("R10 restart");
  endtask

  initial begin
    t_reset_state();
    t_full(13'h0023, 3'b000, 2'b00, "cfg A");
    t_full(13'h1ABC, 3'b101, 2'b11, "cfg B");
    t_full(13'h0037, 3'b010, 2'b10, "cfg C");
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule